// File: doc/BRIEF.md
# Guarded Video Resynchronization FIFO

This block carries pixel words from a recovered link clock into an output pixel clock. A small dual-port store sits between the two domains. The write side advances its pointer on every valid word, and the pointer is passed to the read side as Gray code through a two-flop synchronizer. Once the read side has started, it pulls one word per pixel clock. It watches how far its read pointer trails the synchronized write pointer. If that distance collapses to zero or grows to the full depth, the read pointer is moved so that it trails by half the depth. Each such recentering is counted.

Two guards protect downstream video. A run of recenterings that come too close together blanks the output data. A video PLL that has lost lock also blanks the output data, unless software has turned that guard off. Blanking clears only the data. The valid strobe keeps its cadence, so downstream timing generators stay in step. The block can also restart its read side by itself when lock returns. A sticky flag records that blanking took place.

The read-side controller is a four-state machine:
- FILL: no output. It waits for the separation to reach half depth, then moves to RUN.
- RUN: streaming. A recentering moves it to GUARD.
- GUARD: the window after one recentering. A further recentering moves it to KILL, or keeps it in GUARD when the blanking guard is disabled. When the window runs out quietly, it returns to RUN.
- KILL: output blanked. A further recentering restarts the window. When the window runs out quietly, it returns to RUN.

A relock restart sends any state to FILL.

Top module: `vid_resync_fifo`

## Requirements
- R1: When both clocks run at the same rate and no guard is active, every written word appears once on `rd_data`, in write order, with `rd_valid` high.
- R2: After reset `rd_valid`, `rd_data`, `kill_flag` and `resync_cnt` are all zero. Reading starts only once the synchronized separation has reached DEPTH/2, and the first word read is the first word written.
- R3: Whenever `rd_valid` is low, `rd_data` is zero.
- R4: While streaming, a separation of 0, or of DEPTH or more, moves the read pointer to DEPTH/2 behind the synchronized write pointer. Each such event adds exactly one to `resync_cnt`, and the count does not move while the separation stays in range.
- R5: A recentering that comes within 2*DEPTH read cycles of the previous one forces `rd_data` to zero while `rd_valid` keeps pulsing. The output stays blanked until 2*DEPTH read cycles pass with no recentering.
- R6: With `kill_dis` = 1, repeated recenterings never blank the output.
- R7: With `kill_unlocked` = 1, `rd_data` is zero while the synchronized `pll_lock` is low, and `rd_valid` is unaffected.
- R8: With `kill_unlocked` = 0, data passes in order whatever the state of `pll_lock`.
- R9: With `relock_reset` = 1, a low-to-high transition of the synchronized `pll_lock` snaps the read pointer onto the write pointer. It drops `rd_valid` until half depth has refilled and clears `kill_flag`.
- R10: With `relock_reset` = 0, a rising `pll_lock` leaves the read stream uninterrupted.
- R11: `kill_flag` goes high on any cycle in which a streamed word was blanked. It stays high until reset or a relock restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered link clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | DATA_W | Pixel word to store |
| rd_clk | input | 1 | Output pixel clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_valid | output | 1 | Output word strobe |
| rd_data | output | DATA_W | Output pixel word, zero when blanked |
| pll_lock | input | 1 | Video PLL lock indication, asynchronous |
| kill_dis | input | 1 | 1 disables blanking on frequent recentering |
| kill_unlocked | input | 1 | 1 blanks output while unlocked |
| relock_reset | input | 1 | 1 restarts the read side on lock return |
| resync_cnt | output | CNT_W | Wrapping count of recentering events |
| kill_flag | output | 1 | Sticky record that output was blanked |

## Verification
The hardest situation to reach from the ports is two recenterings inside one window. With the clocks at equal rates the separation never drifts, so no recentering happens on its own. The bench therefore stops the write stream while reads continue. The separation drains to zero, the read pointer is recentered, and the separation drains again after DEPTH/2 reads. That is well inside the 2*DEPTH window, so the KILL state is entered and held. Writes then resume, and the bench confirms that the window runs out, the count freezes and in-order data returns. The same stall with `kill_dis` set shows stale but non-zero data instead.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_RUN   = 2'd1,
        ST_GUARD = 2'd2,
        ST_KILL  = 2'd3
    } rd_state_t;

endpackage

// File: rtl/vrf_sync_bus.sv
module vrf_sync_bus #(
    parameter int W           = 4,
    parameter bit GRAY_DECODE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_in;
            stage2 <= stage1;
        end
    end

    generate
        if (GRAY_DECODE) begin : g_gray
            logic [W-1:0] acc;
            always_comb begin
                acc        = '0;
                acc[W-1]   = stage2[W-1];
                for (int i = W - 2; i >= 0; i--) begin
                    acc[i] = acc[i+1] ^ stage2[i];
                end
            end
            assign q_out = acc;
        end else begin : g_plain
            assign q_out = stage2;
        end
    endgenerate

endmodule

// File: rtl/vrf_wr_side.sv
module vrf_wr_side #(
    parameter int ADDR_W = 3
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] bin_q;
    logic [PW-1:0] bin_nx;

    always_comb begin
        bin_nx = bin_q + PW'(1);
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            bin_q <= '0;
            wgray <= '0;
        end else if (wr_valid) begin
            bin_q <= bin_nx;
            wgray <= bin_nx ^ (bin_nx >> 1);
        end
    end

    assign waddr = bin_q[ADDR_W-1:0];

endmodule

// File: rtl/vrf_mem.sv
module vrf_mem #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 3
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/vrf_rd_ctrl.sv
module vrf_rd_ctrl
    import vrf_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic [ADDR_W:0]   wptr_bin,
    input  logic              lock_s,
    input  logic              kill_dis,
    input  logic              kill_unlocked,
    input  logic              relock_reset,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  resync_cnt,
    output logic              kill_flag,
    output rd_state_t         state,
    output logic              zero_req,
    output logic              relock_evt
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;
    localparam int HALF  = DEPTH / 2;
    localparam int WIN   = 2 * DEPTH;
    localparam int WW    = $clog2(WIN) + 1;

    rd_state_t     state_nx;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] sep;
    logic [WW-1:0] win_cnt;
    logic          lock_d;
    logic          reading;
    logic          resync_hit;
    logic          win_done;

    // separation between synchronized write pointer and read pointer
    always_comb begin
        sep        = wptr_bin - rd_ptr;
        reading    = (state != ST_FILL);
        relock_evt = lock_s && !lock_d && relock_reset;
        resync_hit = reading && !relock_evt &&
                     ((sep == '0) || (sep > PW'(DEPTH - 1)));
        win_done   = (win_cnt == '0);
    end

    // state register
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: begin
                if (sep >= PW'(HALF)) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (resync_hit) begin
                    state_nx = ST_GUARD;
                end
            end
            ST_GUARD: begin
                if (resync_hit) begin
                    state_nx = kill_dis ? ST_GUARD : ST_KILL;
                end else if (win_done) begin
                    state_nx = ST_RUN;
                end
            end
            ST_KILL: begin
                if (resync_hit) begin
                    state_nx = ST_KILL;
                end else if (win_done) begin
                    state_nx = ST_RUN;
                end
            end
        endcase
        if (relock_evt) begin
            state_nx = ST_FILL;
        end
    end

    // blanking request from either guard
    always_comb begin
        zero_req = ((state == ST_KILL) && !kill_dis) ||
                   (kill_unlocked && !lock_s);
        rd_addr  = rd_ptr[ADDR_W-1:0];
    end

    // pointer, window, counter and output registers
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rd_ptr     <= '0;
            win_cnt    <= '0;
            lock_d     <= 1'b0;
            resync_cnt <= '0;
            kill_flag  <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            lock_d <= lock_s;

            if (relock_evt) begin
                rd_ptr <= wptr_bin;
            end else if (resync_hit) begin
                rd_ptr <= wptr_bin - PW'(HALF);
            end else if (reading) begin
                rd_ptr <= rd_ptr + PW'(1);
            end

            if (relock_evt) begin
                win_cnt <= '0;
            end else if (resync_hit) begin
                win_cnt <= WW'(WIN - 1);
            end else if (!win_done) begin
                win_cnt <= win_cnt - WW'(1);
            end

            if (resync_hit) begin
                resync_cnt <= resync_cnt + CNT_W'(1);
            end

            if (relock_evt) begin
                kill_flag <= 1'b0;
            end else if (reading && zero_req) begin
                kill_flag <= 1'b1;
            end

            rd_valid <= reading;
            rd_data  <= (reading && !zero_req) ? mem_rdata : '0;
        end
    end

endmodule

// File: rtl/vid_resync_fifo.sv
module vid_resync_fifo
    import vrf_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pll_lock,
    input  logic              kill_dis,
    input  logic              kill_unlocked,
    input  logic              relock_reset,
    output logic [CNT_W-1:0]  resync_cnt,
    output logic              kill_flag
);

    localparam int PW = ADDR_W + 1;

    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     wptr_rd;
    logic [DATA_W-1:0] mem_rdata;
    logic              lock_s;
    logic              zero_req;
    logic              relock_evt;
    rd_state_t         rd_st;

    vrf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_valid (wr_valid),
        .waddr    (waddr),
        .wgray    (wgray)
    );

    vrf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (wr_valid),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    vrf_sync_bus #(.W(PW), .GRAY_DECODE(1'b1)) u_ptr_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d_in  (wgray),
        .q_out (wptr_rd)
    );

    vrf_sync_bus #(.W(1), .GRAY_DECODE(1'b0)) u_lock_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d_in  (pll_lock),
        .q_out (lock_s)
    );

    vrf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
        .rd_clk        (rd_clk),
        .rd_rst_n      (rd_rst_n),
        .wptr_bin      (wptr_rd),
        .lock_s        (lock_s),
        .kill_dis      (kill_dis),
        .kill_unlocked (kill_unlocked),
        .relock_reset  (relock_reset),
        .mem_rdata     (mem_rdata),
        .rd_addr       (raddr),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .resync_cnt    (resync_cnt),
        .kill_flag     (kill_flag),
        .state         (rd_st),
        .zero_req      (zero_req),
        .relock_evt    (relock_evt)
    );

endmodule

// File: rtl/vrf_chk.sv
module vrf_chk
    import vrf_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 8
) (
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              kill_dis,
    input logic              kill_unlocked,
    input logic [CNT_W-1:0]  resync_cnt,
    input logic              kill_flag,
    input rd_state_t         st,
    input logic              lock_s,
    input logic              zero_req,
    input logic              relock_evt
);

    AST_FILL_SILENT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $past(st == ST_FILL) |-> !rd_valid); // R2

    AST_IDLE_ZERO: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_valid |-> (rd_data == '0)); // R3

    AST_CNT_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (resync_cnt == $past(resync_cnt)) ||
        (resync_cnt == $past(resync_cnt) + CNT_W'(1))); // R4

    AST_KILL_VIA_GUARD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (st == ST_KILL && $past(st) != ST_KILL) |-> ($past(st) == ST_GUARD)); // R5

    AST_KILL_DISABLED: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (kill_dis && st != ST_KILL) |=> (st != ST_KILL)); // R6

    AST_UNLOCK_BLANK: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $past(kill_unlocked && !lock_s) |-> (rd_data == '0)); // R7

    AST_RELOCK_REFILL: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        relock_evt |=> (st == ST_FILL && !kill_flag)); // R9

    AST_STICKY_SET: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $past(zero_req && st != ST_FILL && !relock_evt) |-> kill_flag); // R11

endmodule

bind vid_resync_fifo vrf_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .rd_clk        (rd_clk),
    .rd_rst_n      (rd_rst_n),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .kill_dis      (kill_dis),
    .kill_unlocked (kill_unlocked),
    .resync_cnt    (resync_cnt),
    .kill_flag     (kill_flag),
    .st            (rd_st),
    .lock_s        (lock_s),
    .zero_req      (zero_req),
    .relock_evt    (relock_evt)
);

// File: tb/vid_resync_fifo_tb.sv
module vid_resync_fifo_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 24;
    localparam int ADDR_W     = 3;
    localparam int CNT_W      = 8;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              pll_lock = 1'b1;
    logic              kill_dis = 1'b0;
    logic              kill_unlocked = 1'b1;
    logic              relock_reset = 1'b1;
    logic [CNT_W-1:0]  resync_cnt;
    logic              kill_flag;

    int                n_cmp = 0;
    int                n_bad = 0;
    bit                done = 1'b0;
    bit                wr_run = 1'b0;
    bit                sb_on = 1'b0;
    bit                realign = 1'b0;
    bit                gap_seen = 1'b0;
    string             sb_tag = "R1";
    logic [DATA_W-1:0] wr_cnt = 24'd1;
    logic [DATA_W-1:0] exp_q[$];

    vid_resync_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .wr_clk        (wr_clk),
        .wr_rst_n      (wr_rst_n),
        .wr_valid      (wr_valid),
        .wr_data       (wr_data),
        .rd_clk        (rd_clk),
        .rd_rst_n      (rd_rst_n),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .pll_lock      (pll_lock),
        .kill_dis      (kill_dis),
        .kill_unlocked (kill_unlocked),
        .relock_reset  (relock_reset),
        .resync_cnt    (resync_cnt),
        .kill_flag     (kill_flag)
    );

    initial forever #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #(CLK_PERIOD / 2) rd_clk = ~rd_clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    // driver: one word per write clock while running, pushed to the scoreboard
    task automatic drive_word();
        wr_valid = 1'b1;
        wr_data  = wr_cnt;
        exp_q.push_back(wr_cnt);
        wr_cnt   = wr_cnt + 1'b1;
    endtask

    initial begin
        forever begin
            @(negedge wr_clk);
            if (wr_run && wr_rst_n) drive_word();
            else wr_valid = 1'b0;
        end
    end

    // monitor: compares streamed words against the expected queue
    initial begin
        forever begin
            @(negedge rd_clk);
            if (rd_rst_n && !done) begin
                if (!rd_valid) begin
                    gap_seen = 1'b1;
                    chk(rd_data == '0, "R3", "data while invalid", rd_data, 0);
                end else if (sb_on) begin
                    if (realign) begin
                        while (exp_q.size() > 0 && exp_q[0] != rd_data) void'(exp_q.pop_front());
                        realign = 1'b0;
                    end
                    if (exp_q.size() == 0) begin
                        chk(1'b0, sb_tag, "unexpected word", rd_data, -1);
                    end else begin
                        chk(rd_data == exp_q[0], sb_tag, "stream word", rd_data, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge rd_clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c0;
        int c1;
        rd_wait(5);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        rd_wait(1);
        // R2: reset state
        chk(rd_valid == 1'b0, "R2", "valid after reset", rd_valid, 0);
        chk(rd_data == '0, "R2", "data after reset", rd_data, 0);
        chk(kill_flag == 1'b0, "R2", "flag after reset", kill_flag, 0);
        chk(resync_cnt == '0, "R2", "count after reset", resync_cnt, 0);

        // R1/R2: strict in-order stream from the very first word
        rd_wait(4);
        sb_tag = "R1";
        sb_on  = 1'b1;
        wr_run = 1'b1;
        rd_wait(20);
        chk(rd_valid == 1'b1, "R2", "streaming started", rd_valid, 1);
        rd_wait(180);
        chk(resync_cnt == '0, "R4", "no resync at steady rate", resync_cnt, 0);

        // R7/R11: unlock blanks data, valid keeps pulsing
        sb_on    = 1'b0;
        pll_lock = 1'b0;
        rd_wait(8);
        for (int i = 0; i < 6; i++) begin
            chk(rd_valid == 1'b1, "R7", "valid while unlocked", rd_valid, 1);
            chk(rd_data == '0, "R7", "data while unlocked", rd_data, 0);
            rd_wait(1);
        end
        chk(kill_flag == 1'b1, "R11", "flag after unlock blank", kill_flag, 1);

        // R8: guard off, data passes while unlocked
        kill_unlocked = 1'b0;
        rd_wait(6);
        sb_tag  = "R8";
        realign = 1'b1;
        sb_on   = 1'b1;
        rd_wait(50);

        // R10: lock returns without restart
        relock_reset = 1'b0;
        sb_tag       = "R10";
        gap_seen     = 1'b0;
        pll_lock     = 1'b1;
        rd_wait(30);
        chk(gap_seen == 1'b0, "R10", "valid gap on relock", gap_seen, 0);
        chk(kill_flag == 1'b1, "R11", "flag sticky across relock", kill_flag, 1);
        sb_on = 1'b0;

        // R9: lock returns with restart
        kill_unlocked = 1'b1;
        pll_lock      = 1'b0;
        rd_wait(10);
        relock_reset = 1'b1;
        gap_seen     = 1'b0;
        pll_lock     = 1'b1;
        rd_wait(30);
        chk(gap_seen == 1'b1, "R9", "refill gap on relock", gap_seen, 1);
        chk(kill_flag == 1'b0, "R9", "flag cleared by restart", kill_flag, 0);
        sb_tag  = "R9";
        realign = 1'b1;
        sb_on   = 1'b1;
        rd_wait(40);
        chk(resync_cnt == '0, "R4", "no resync from restart", resync_cnt, 0);
        sb_on = 1'b0;

        // R5: write stall forces repeated recentering and blanking
        wr_run = 1'b0;
        rd_wait(40);
        chk(resync_cnt >= 2, "R4", "recenters counted", resync_cnt, 2);
        chk(rd_valid == 1'b1, "R5", "valid during blank", rd_valid, 1);
        chk(rd_data == '0, "R5", "data blanked", rd_data, 0);
        chk(kill_flag == 1'b1, "R11", "flag after excess blank", kill_flag, 1);
        wr_run = 1'b1;
        rd_wait(40);
        c1 = int'(resync_cnt);
        rd_wait(30);
        chk(int'(resync_cnt) == c1, "R4", "count frozen in range", resync_cnt, c1);
        sb_tag  = "R5";
        realign = 1'b1;
        sb_on   = 1'b1;
        rd_wait(40);
        sb_on = 1'b0;

        // R6: same stall with blanking disabled shows stale data
        kill_dis = 1'b1;
        c0       = int'(resync_cnt);
        wr_run   = 1'b0;
        rd_wait(40);
        chk(int'(resync_cnt) > c0, "R4", "recenters while disabled", resync_cnt, c0 + 1);
        chk(rd_valid == 1'b1, "R6", "valid during stall", rd_valid, 1);
        chk(rd_data != '0, "R6", "data not blanked", rd_data, 1);
        wr_run = 1'b1;
        rd_wait(40);
        sb_tag  = "R6";
        realign = 1'b1;
        sb_on   = 1'b1;
        rd_wait(30);
        sb_on    = 1'b0;
        kill_dis = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule